// File: doc/BRIEF.md
# UART Loopback and FIFO Debug Path

This block wraps the serial pins and the two character FIFOs of a UART with the paths used for self-test. A programmable scaler produces a tick at eight times the baud rate, so the reload value is the system clock frequency divided by eight times the baud rate, minus one. Two small serial stubs, one for transmit and one for receive, run from that tick and move 8-bit characters. Each character goes out as one low start bit, then eight data bits with the least significant bit first, then one high stop bit.

Setting the loop control bit turns the serial path back on itself. The transmit line feeds the receiver, and the receiver's ready-to-send handshake feeds the transmitter's clear-to-send input. The external outputs sit at their idle levels and the external inputs are ignored. Setting the debug control bit silences the transmitter. Software can then drain the transmit FIFO and fill the receive FIFO through one debug data port. A receive-interrupt pulse fires for every character that enters the receive FIFO while that interrupt is enabled.

Top module: `uart_test_path`

## Requirements
- R1: During and right after reset, pin_txd is high, both FIFOs report empty and not full, rx_irq is low and dbg_rdata is zero.
- R2: In normal mode a character is sent on pin_txd as a start bit of 0, then data bits 0 to 7, then a stop bit of 1. Each bit lasts 8*(cfg_scaler+1) clock cycles.
- R3: Outside loopback the transmitter starts a character only while pin_ctsn is low. While pin_ctsn is high, pin_txd stays high and the transmit FIFO is not popped.
- R4: In loopback a transmitted character arrives in the receive FIFO unchanged, while the levels on pin_rxd and pin_ctsn have no effect.
- R5: In loopback pin_txd and pin_rtsn stay high at all times.
- R6: In loopback the transmitter is paced by the receiver's own ready-to-send. With the receiver disabled, no character leaves the transmit FIFO, and enabling the receiver releases it.
- R7: In debug mode a pulse on dbg_rd pops the head of the transmit FIFO, and that value is on dbg_rdata one cycle later. A read of an empty FIFO returns zero and leaves the FIFO state unchanged.
- R8: In debug mode a pulse on dbg_wr pushes dbg_wdata into the receive FIFO, and it is read back in order through host_rx_data.
- R9: In debug mode pin_txd stays high and the transmitter does not drain the transmit FIFO.
- R10: rx_irq is high for exactly the one cycle after each accepted receive-FIFO push while cfg_rx_irq_en is set, and never while it is clear.
- R11: Each FIFO holds 16 entries. The full flag rises at the 16th write, and a write while full is dropped without raising rx_irq.
- R12: Outside loopback pin_rtsn is low while the receiver is enabled and the receive FIFO is not full. It goes high while that FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_scaler | input | SCW | Tick reload value; tick period is cfg_scaler+1 cycles |
| cfg_loop | input | 1 | Internal loopback of data and flow control |
| cfg_debug | input | 1 | Back-door FIFO access, transmitter silenced |
| cfg_tx_en | input | 1 | Transmitter enable |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_rx_irq_en | input | 1 | Receive interrupt enable |
| host_tx_wr | input | 1 | Push host_tx_data into the transmit FIFO |
| host_tx_data | input | DW | Transmit write data |
| host_rx_rd | input | 1 | Pop the receive FIFO |
| host_rx_data | output | DW | Head of the receive FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| dbg_rd | input | 1 | Debug pop of the transmit FIFO |
| dbg_rdata | output | DW | Value captured by the last debug pop |
| dbg_wr | input | 1 | Debug push into the receive FIFO |
| dbg_wdata | input | DW | Debug push data |
| pin_txd | output | 1 | Serial transmit pin, idle high |
| pin_rxd | input | 1 | Serial receive pin |
| pin_rtsn | output | 1 | Ready-to-send pin, active low |
| pin_ctsn | input | 1 | Clear-to-send pin, active low |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
FIFO flags and the head value change on the clock edge that takes a push or pop, so the bench samples them at the next falling edge. dbg_rdata and rx_irq each pass through one register and are due at that same falling edge. The bench checks rx_irq there and checks again one cycle later to see that the pulse is gone. Serial bits are due 8*(cfg_scaler+1) cycles apart, counted from the first low sample of the start bit: the bench measures the start bit's length exactly and samples the other bits at their centres. A character in loopback only reaches the receive FIFO after the synchronising and mid-bit sampling delays. The bench therefore polls rx_empty within a fixed bound and checks pin levels on every cycle of that wait.

// File: rtl/utp_pkg.sv
// Shared types and constants for the UART test path.
// Assumes a fixed oversampling ratio of eight ticks per serial bit.
package utp_pkg;
    localparam int OVERSAMPLE = 8;
    localparam int SUBW       = $clog2(OVERSAMPLE);
    localparam int MID_TICK   = OVERSAMPLE / 2 - 1;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/utp_baud_gen.sv
// Baud scaler: emits a single-cycle tick every (scaler+1) cycles.
// Assumes scaler is held stable while characters are in flight.
module utp_baud_gen #(
    parameter int SCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SCW-1:0] scaler,
    output logic           tick
);
    logic [SCW-1:0] cnt;

    assign tick = (cnt == '0);

    // Down-counter that reloads from the scaler after reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (cnt == '0) cnt <= scaler;
        else               cnt <= cnt - 1'b1;
    end

    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && scaler != '0) |=> !tick);
endmodule

// File: rtl/utp_fifo.sv
// Show-ahead synchronous FIFO: head is visible while not empty.
// Assumes writes when full and reads when empty are dropped by the FIFO itself.
module utp_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(count));
    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> $stable(count));
endmodule

// File: rtl/utp_tx_stub.sv
// Transmit serialiser stub: start bit, DW data bits LSB first, stop bit.
// Assumes data is valid whenever go is high; pops exactly once per character.
module utp_tx_stub #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          go,
    input  logic [DW-1:0] data,
    output logic          pop,
    output logic          line,
    output logic          busy
);
    import utp_pkg::*;
    localparam int FRAME = DW + 2;
    localparam int BW    = $clog2(FRAME + 1);

    logic [FRAME-1:0] shreg;
    logic [BW-1:0]    bits_left;
    logic [SUBW-1:0]  sub;

    assign pop  = !busy && tick && go;
    assign line = busy ? shreg[0] : 1'b1;

    // Load a frame on a tick and shift one bit every OVERSAMPLE ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            shreg     <= '1;
            bits_left <= '0;
            sub       <= '0;
        end else if (pop) begin
            busy      <= 1'b1;
            shreg     <= {1'b1, data, 1'b0};
            bits_left <= BW'(FRAME);
            sub       <= '0;
        end else if (busy && tick) begin
            if (sub == SUBW'(OVERSAMPLE - 1)) begin
                sub   <= '0;
                shreg <= {1'b1, shreg[FRAME-1:1]};
                if (bits_left == BW'(1)) busy <= 1'b0;
                else                     bits_left <= bits_left - 1'b1;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end
endmodule

// File: rtl/utp_rx_stub.sv
// Receive deserialiser stub: detects a start bit, samples at bit centres,
// and pulses done only when the stop bit is high. Assumes a synchronous line.
module utp_rx_stub #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          enable,
    input  logic          line,
    output logic          done,
    output logic [DW-1:0] data
);
    import utp_pkg::*;
    localparam int BCW = $clog2(DW);

    rx_state_e       state;
    logic [SUBW-1:0] sub;
    logic [BCW-1:0]  bitn;

    // Frame reception state machine advanced on oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            sub   <= '0;
            bitn  <= '0;
            data  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!enable) begin
                state <= RX_IDLE;
            end else if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!line) begin
                            state <= RX_START;
                            sub   <= '0;
                        end
                    end
                    RX_START: begin
                        if (sub == SUBW'(MID_TICK)) begin
                            sub   <= '0;
                            bitn  <= '0;
                            state <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (sub == SUBW'(OVERSAMPLE - 1)) begin
                            sub  <= '0;
                            data <= {line, data[DW-1:1]};
                            if (bitn == BCW'(DW - 1)) state <= RX_STOP;
                            else                     bitn  <= bitn + 1'b1;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    default: begin
                        if (sub == SUBW'(OVERSAMPLE - 1)) begin
                            sub   <= '0;
                            done  <= line;
                            state <= RX_IDLE;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_test_path.sv
// UART test-mode path: baud scaler, transmit/receive FIFOs, serial stubs,
// internal loopback of data and flow control, and a debug FIFO port.
// Assumes the pins are asynchronous and are synchronised here with two flops.
module uart_test_path #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int SCW   = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SCW-1:0] cfg_scaler,
    input  logic           cfg_loop,
    input  logic           cfg_debug,
    input  logic           cfg_tx_en,
    input  logic           cfg_rx_en,
    input  logic           cfg_rx_irq_en,
    input  logic           host_tx_wr,
    input  logic [DW-1:0]  host_tx_data,
    input  logic           host_rx_rd,
    output logic [DW-1:0]  host_rx_data,
    output logic           tx_full,
    output logic           tx_empty,
    output logic           rx_full,
    output logic           rx_empty,
    input  logic           dbg_rd,
    output logic [DW-1:0]  dbg_rdata,
    input  logic           dbg_wr,
    input  logic [DW-1:0]  dbg_wdata,
    output logic           pin_txd,
    input  logic           pin_rxd,
    output logic           pin_rtsn,
    input  logic           pin_ctsn
    ,
    output logic           rx_irq
);
    logic          tick;
    logic          rxd_s1, rxd_s2, ctsn_s1, ctsn_s2;
    logic          tx_line, tx_busy, tx_go, tx_stub_pop, tx_pop, dbg_pop;
    logic [DW-1:0] tx_head;
    logic          rx_line, rx_done;
    logic [DW-1:0] rx_word;
    logic          rx_push, rx_ok;
    logic [DW-1:0] rx_push_data;
    logic          rts_int_n, cts_int_n;

    // Two-flop synchronisers for the external inputs, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd_s1  <= 1'b1;
            rxd_s2  <= 1'b1;
            ctsn_s1 <= 1'b1;
            ctsn_s2 <= 1'b1;
        end else begin
            rxd_s1  <= pin_rxd;
            rxd_s2  <= rxd_s1;
            ctsn_s1 <= pin_ctsn;
            ctsn_s2 <= ctsn_s1;
        end
    end

    // Loopback routing and idle forcing of the pins.
    always_comb begin
        rts_int_n = !(cfg_rx_en && !rx_full);
        cts_int_n = cfg_loop ? rts_int_n : ctsn_s2;
        rx_line   = cfg_loop ? tx_line : rxd_s2;
        pin_txd   = (cfg_loop || cfg_debug) ? 1'b1 : tx_line;
        pin_rtsn  = cfg_loop ? 1'b1 : rts_int_n;
    end

    // Transmit side: hardware drain or debug drain of the FIFO.
    always_comb begin
        tx_go   = cfg_tx_en && !cfg_debug && !cts_int_n && !tx_empty;
        dbg_pop = cfg_debug && dbg_rd && !tx_empty;
        tx_pop  = tx_stub_pop || dbg_pop;
    end

    // Receive side: debug writes replace received characters in debug mode.
    always_comb begin
        rx_push      = cfg_debug ? dbg_wr : rx_done;
        rx_push_data = cfg_debug ? dbg_wdata : rx_word;
        rx_ok        = rx_push && !rx_full;
    end

    // Debug read capture and receive interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_rdata <= '0;
            rx_irq    <= 1'b0;
        end else begin
            if (cfg_debug && dbg_rd) dbg_rdata <= tx_empty ? '0 : tx_head;
            rx_irq <= cfg_rx_irq_en && rx_ok;
        end
    end

    utp_baud_gen #(.SCW(SCW)) u_baud (
        .clk(clk), .rst_n(rst_n), .scaler(cfg_scaler), .tick(tick)
    );

    utp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .push(host_tx_wr), .wdata(host_tx_data),
        .pop(tx_pop), .head(tx_head), .full(tx_full), .empty(tx_empty)
    );

    utp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_push_data),
        .pop(host_rx_rd), .head(host_rx_data), .full(rx_full), .empty(rx_empty)
    );

    utp_tx_stub #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(tx_go), .data(tx_head),
        .pop(tx_stub_pop), .line(tx_line), .busy(tx_busy)
    );

    utp_rx_stub #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(cfg_rx_en),
        .line(rx_line), .done(rx_done), .data(rx_word)
    );

    assert_start_needs_cts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(!cts_int_n));
    assert_debug_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_debug && $past(cfg_debug)) |-> !$rose(tx_busy));
    assert_irq_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(cfg_rx_irq_en));
endmodule

// File: tb/uart_test_path_test.sv
module uart_test_path_test;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] cfg_scaler = 16'd1;
    logic cfg_loop = 0, cfg_debug = 0, cfg_tx_en = 0, cfg_rx_en = 0, cfg_rx_irq_en = 0;
    logic host_tx_wr = 0, host_rx_rd = 0, dbg_rd = 0, dbg_wr = 0;
    logic [DW-1:0] host_tx_data = '0, dbg_wdata = '0;
    logic [DW-1:0] host_rx_data, dbg_rdata;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic pin_txd, pin_rtsn, rx_irq;
    logic pin_rxd = 1'b1, pin_ctsn = 1'b1;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    uart_test_path uut (
        .clk(clk), .rst_n(rst_n), .cfg_scaler(cfg_scaler), .cfg_loop(cfg_loop),
        .cfg_debug(cfg_debug), .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
        .cfg_rx_irq_en(cfg_rx_irq_en), .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
        .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data), .tx_full(tx_full),
        .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty), .dbg_rd(dbg_rd),
        .dbg_rdata(dbg_rdata), .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata), .pin_txd(pin_txd),
        .pin_rxd(pin_rxd), .pin_rtsn(pin_rtsn), .pin_ctsn(pin_ctsn), .rx_irq(rx_irq)
    );

    function automatic logic frame_bit(input logic [DW-1:0] b, input int k);
        if (k == 0) return 1'b0;
        if (k == DW + 1) return 1'b1;
        return b[k-1];
    endfunction

    function automatic logic [DW-1:0] exp_dbg_read(input bit was_empty, input logic [DW-1:0] m);
        return was_empty ? '0 : m;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_tx(input logic [DW-1:0] b);
        host_tx_wr = 1; host_tx_data = b;
        @(negedge clk);
        host_tx_wr = 0;
    endtask

    task automatic dbg_read(output logic [DW-1:0] b);
        dbg_rd = 1;
        @(negedge clk);
        dbg_rd = 0;
        b = dbg_rdata;
    endtask

    task automatic dbg_write(input logic [DW-1:0] b, input bit irq_exp, input string req);
        dbg_wr = 1; dbg_wdata = b;
        @(negedge clk);
        dbg_wr = 0;
        chk(rx_irq == irq_exp, req, rx_irq, irq_exp);
    endtask

    task automatic pop_rx(output logic [DW-1:0] b);
        b = host_rx_data;
        host_rx_rd = 1;
        @(negedge clk);
        host_rx_rd = 0;
    endtask

    // Wait for a loopback character, watching the idle pins and counting irq pulses.
    task automatic wait_rx(output bit got, output int pin_bad, output int irqs);
        got = 0; pin_bad = 0; irqs = 0;
        for (int i = 0; i < 3000 && !got; i++) begin
            @(negedge clk);
            if (!pin_txd || !pin_rtsn) pin_bad++;
            if (rx_irq) irqs++;
            if (!rx_empty) got = 1;
        end
        @(negedge clk);
        if (rx_irq) irqs++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] b, q [$];
        bit got, stuck, busy_seen;
        int bad, irqs, n;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(pin_txd == 1 && tx_empty && rx_empty && !tx_full && !rx_full && !rx_irq && dbg_rdata == 0,
            "R1 reset", {pin_txd, tx_empty, rx_empty, tx_full, rx_full, rx_irq}, 6'b111000);
        rst_n = 1;
        @(negedge clk);
        chk(pin_txd == 1 && tx_empty && rx_empty && !rx_irq && dbg_rdata == 0,
            "R1 after reset", {pin_txd, tx_empty, rx_empty, rx_irq}, 4'b1110);

        // R12: ready-to-send follows receiver enable
        cfg_rx_en = 1; cfg_tx_en = 1;
        @(negedge clk);
        chk(pin_rtsn == 0, "R12 rtsn low when ready", pin_rtsn, 0);

        // R3: clear-to-send high holds the transmitter
        push_tx(8'hA5);
        stuck = 1;
        repeat (300) begin @(negedge clk); if (!pin_txd) stuck = 0; end
        chk(stuck && !tx_empty, "R3 held by ctsn", {stuck, tx_empty}, 2'b10);

        // R2: frame shape and bit time with cfg_scaler=1 (16 cycles per bit)
        pin_ctsn = 0;
        got = 0;
        for (int i = 0; i < 500 && !got; i++) begin @(negedge clk); if (!pin_txd) got = 1; end
        chk(got, "R3 starts after ctsn low", got, 1);
        n = 0;
        while (!pin_txd && n < 100) begin n++; @(negedge clk); end
        chk(n == 16, "R2 start bit length", n, 16);
        repeat (8) @(negedge clk);
        for (int k = 1; k <= DW + 1; k++) begin
            chk(pin_txd == frame_bit(8'hA5, k), "R2 frame bit", pin_txd, frame_bit(8'hA5, k));
            repeat (16) @(negedge clk);
        end
        chk(tx_empty, "R2 fifo drained", tx_empty, 1);

        // R4 R5 R10: loopback delivers data, pins idle, external inputs ignored
        cfg_loop = 1; cfg_rx_irq_en = 1; pin_rxd = 0; pin_ctsn = 1;
        for (int r = 0; r < 3; r++) begin
            b = DW'($urandom);
            push_tx(b);
            wait_rx(got, bad, irqs);
            chk(got && host_rx_data == b, "R4 loopback data", host_rx_data, b);
            chk(bad == 0, "R5 pins idle in loopback", bad, 0);
            chk(irqs == 1, "R10 one irq per character", irqs, 1);
            pop_rx(b);
        end

        // R6: loopback flow control uses receiver readiness
        cfg_rx_en = 0;
        push_tx(8'h11);
        repeat (400) @(negedge clk);
        chk(!tx_empty && rx_empty, "R6 held while receiver off", {tx_empty, rx_empty}, 2'b01);
        cfg_rx_en = 1;
        wait_rx(got, bad, irqs);
        chk(got && host_rx_data == 8'h11, "R6 released", host_rx_data, 8'h11);
        pop_rx(b);
        pin_rxd = 1; cfg_loop = 0; pin_ctsn = 0;
        repeat (4) @(negedge clk);

        // R9: debug mode silences the transmitter
        cfg_debug = 1;
        push_tx(8'h3C); push_tx(8'hC3);
        stuck = 1; busy_seen = 0;
        repeat (300) begin @(negedge clk); if (!pin_txd) stuck = 0; end
        chk(stuck && !tx_empty, "R9 no transmit in debug", {stuck, tx_empty}, 2'b10);

        // R7: debug reads pop in order, empty read returns zero
        dbg_read(b); chk(b == 8'h3C, "R7 debug read 1", b, 8'h3C);
        dbg_read(b); chk(b == 8'hC3, "R7 debug read 2", b, 8'hC3);
        chk(tx_empty, "R7 empty after reads", tx_empty, 1);
        dbg_read(b); chk(b == exp_dbg_read(1, 8'hC3), "R7 empty read zero", b, 0);
        chk(tx_empty, "R7 empty read keeps state", tx_empty, 1);
        push_tx(8'h5E);
        dbg_read(b); chk(b == 8'h5E, "R7 pointers intact", b, 8'h5E);

        // R11: transmit FIFO depth and dropped 17th write
        for (int i = 0; i < 17; i++) push_tx(DW'(i + 8'h40));
        chk(tx_full, "R11 tx full", tx_full, 1);
        for (int i = 0; i < 16; i++) begin
            dbg_read(b); chk(b == DW'(i + 8'h40), "R11 tx order", b, DW'(i + 8'h40));
        end
        dbg_read(b); chk(b == 0, "R11 17th dropped", b, 0);

        // R8 R10 R11 R12: receive FIFO fill via debug writes
        for (int i = 0; i < 16; i++) begin
            dbg_write(DW'(8'h80 + i), 1, "R10 irq on debug write");
            if (i == 0) begin
                @(negedge clk);
                chk(!rx_irq, "R10 pulse is one cycle", rx_irq, 0);
            end
        end
        chk(rx_full && pin_rtsn, "R12 rtsn high when full", {rx_full, pin_rtsn}, 2'b11);
        dbg_write(8'hFF, 0, "R11 no irq on dropped write");
        for (int i = 0; i < 16; i++) begin
            pop_rx(b); chk(b == DW'(8'h80 + i), "R8 rx order", b, DW'(8'h80 + i));
        end
        chk(rx_empty, "R11 overflow dropped", rx_empty, 1);

        // R10: interrupt disabled
        cfg_rx_irq_en = 0;
        dbg_write(8'h77, 0, "R10 irq disabled");
        pop_rx(b); chk(b == 8'h77, "R8 single write", b, 8'h77);

        // Random rounds: R7 R8 R10
        for (int r = 0; r < 30; r++) begin
            n = $urandom_range(1, 16);
            cfg_rx_irq_en = $urandom_range(0, 1);
            q.delete();
            for (int i = 0; i < n; i++) begin b = DW'($urandom); q.push_back(b); push_tx(b); end
            for (int i = 0; i < n; i++) begin
                dbg_read(b); chk(b == q[i], "R7 random drain", b, q[i]);
            end
            q.delete();
            for (int i = 0; i < n; i++) begin
                b = DW'($urandom); q.push_back(b);
                dbg_write(b, cfg_rx_irq_en, "R10 random irq");
            end
            for (int i = 0; i < n; i++) begin
                pop_rx(b); chk(b == q[i], "R8 random fill", b, q[i]);
            end
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule